// File: doc/BRIEF.md
# Light Integration Window Timer

This block produces the integration window for a two-channel light-to-digital converter. It holds an 8-bit timing control register. Two bits of that register choose one of three fixed conversion periods. The fourth code of those two bits hands the window to software, which opens and closes it by writing a control bit. The same register holds a single gain-select bit that applies to both channels together.

Periods are measured in pulses of a time-base `tick` input. The tick count for each fixed code is a parameter, so a bench can run with short periods. In the fixed codes the window is open all the time and repeats back to back. A one-cycle `win_done` pulse marks the end of each window, and `win_ticks` reports how long that window lasted. In the software-timed mode the pulse comes when software closes the window, and `win_ticks` reports the number of ticks seen while the window was open.

Top module: `intwin_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register returns to 0x02 (period code 10, gain low, control bit clear). `win_done` goes low and `win_ticks` goes to zero.
- R2: A write stores `wr_data` with bits 7:5 and bit 2 forced to zero. `rd_data` returns the stored value (mask 0x1B) from the cycle after the write.
- R3: `gain_hi` equals bit 4 of the last write: 1 selects the 16x gain and 0 selects the 1x gain.
- R4: For period code 00, 01 or 10 in bits 1:0, a window ends after TICKS_SHORT, TICKS_MID or TICKS_LONG ticks respectively. In the cycle after the completing tick, `win_done` pulses and `win_ticks` equals that period. The next window starts at once, and `win_open` stays high.
- R5: A write that changes bits 1:0 restarts the tick count from zero without a `win_done`, and a tick in that cycle is dropped. A write that keeps bits 1:0 leaves the count running.
- R6: With bits 1:0 at 11, a write that sets bit 3 opens the window (`win_open` high from the next cycle) with a count of zero. A tick in that write cycle is not counted.
- R7: With bits 1:0 at 11, a write that clears bit 3 while the window is open gives `win_done` in the next cycle, with `win_open` low. `win_ticks` equals the ticks seen while the window was open, counting a tick in the stopping cycle.
- R8: In codes 00, 01 and 10, bit 3 has no effect on `win_open`, `win_done` or the period timing.
- R9: Changing bits 1:0 away from 11 while the window is open closes it without a `win_done`.
- R10: The count in the software-timed window saturates at 2^CNT_W-1.
- R11: `win_done` is high for one cycle per completed window and only after a tick or a write. `win_ticks` holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| gain_hi | output | 1 | Shared gain select, 1 = 16x |
| win_open | output | 1 | Integration window currently open |
| win_done | output | 1 | One-cycle pulse at window end |
| win_ticks | output | CNT_W | Length in ticks of the last completed window |

## Verification
A wrong tick count shows up as a `win_done` pulse that lands on the wrong tick, or a wrong `win_ticks` value. Both are visible in the cycle after the completing tick or after the stop write. A lost or stale code comparison shows up within one window: a spurious or missing pulse after a mode change, or a software bit that disturbs fixed timing. The bench sweeps every fixed code against several tick spacings and every short software window length, and it predicts each pulse position arithmetically.

// File: rtl/intwin_pkg.sv
// Package: shared encodings for the integration window timer.
// Assumes an 8-bit control register with the period code in bits 1:0.
package intwin_pkg;

    typedef enum logic [1:0] {
        PER_SHORT  = 2'b00,
        PER_MID    = 2'b01,
        PER_LONG   = 2'b10,
        PER_MANUAL = 2'b11
    } per_code_e;

    localparam logic [7:0] CTL_RESET = 8'h02;
    localparam logic [7:0] CTL_WMASK = 8'h1B;
    localparam int         GAIN_BIT  = 4;
    localparam int         MAN_BIT   = 3;

endpackage

// File: rtl/intwin_regs.sv
// Module: control register with reserved-bit masking.
// Exposes the stored value and the value it takes at the next edge,
// so that downstream logic can detect mode changes in the write cycle.
module intwin_regs
    import intwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] ctl_q,
    output per_code_e  code_d,
    output logic       man_d
);

    logic [7:0] ctl_d;

    // Next register value: masked write data or hold.
    always_comb begin
        ctl_d = wr_en ? (wr_data & CTL_WMASK) : ctl_q;
    end

    assign code_d = per_code_e'(ctl_d[1:0]);
    assign man_d  = ctl_d[MAN_BIT];

    // Register storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/intwin_period_sel.sv
// Module: maps a fixed period code to its tick count.
// Assumes every tick count is at least 1 and fits in CNT_W bits;
// the manual code returns the longest period, which is unused.
module intwin_period_sel
    import intwin_pkg::*;
#(
    parameter int TICKS_SHORT = 14,
    parameter int TICKS_MID   = 101,
    parameter int TICKS_LONG  = 402,
    parameter int CNT_W       = 16
) (
    input  per_code_e          code,
    output logic [CNT_W-1:0]   period
);

    localparam logic [CNT_W-1:0] LEN_S = CNT_W'(TICKS_SHORT);
    localparam logic [CNT_W-1:0] LEN_M = CNT_W'(TICKS_MID);
    localparam logic [CNT_W-1:0] LEN_L = CNT_W'(TICKS_LONG);

    // Period lookup by code.
    always_comb begin
        case (code)
            PER_SHORT: period = LEN_S;
            PER_MID:   period = LEN_M;
            default:   period = LEN_L;
        endcase
    end

endmodule

// File: rtl/intwin_seq.sv
// Module: window sequencer. Counts ticks, ends fixed windows on period,
// opens and closes software windows on control-bit edges.
// Assumes code/man current and next values come from the register stage.
module intwin_seq
    import intwin_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  per_code_e        code_q,
    input  per_code_e        code_d,
    input  logic             man_q,
    input  logic             man_d,
    input  logic [CNT_W-1:0] period,
    output logic             win_open,
    output logic             win_done,
    output logic [CNT_W-1:0] win_ticks
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt, cnt_n, cnt_sat, ticks_n;
    logic             done_n;
    logic             fixed_q, sw_open_q, sw_open_d, code_chg;

    assign fixed_q   = (code_q != PER_MANUAL);
    assign sw_open_q = (code_q == PER_MANUAL) && man_q;
    assign sw_open_d = (code_d == PER_MANUAL) && man_d;
    assign code_chg  = (code_d != code_q);
    assign cnt_sat   = (cnt == CNT_MAX) ? cnt : cnt + CNT_ONE;
    assign win_open  = fixed_q || man_q;

    // Next-state decision for counter, done pulse and reported length.
    always_comb begin
        cnt_n   = cnt;
        done_n  = 1'b0;
        ticks_n = win_ticks;
        if (code_chg) begin
            cnt_n = '0;
        end else if (fixed_q) begin
            if (tick) begin
                if (cnt == period - CNT_ONE) begin
                    done_n  = 1'b1;
                    ticks_n = period;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + CNT_ONE;
                end
            end
        end else if (sw_open_q && !sw_open_d) begin
            done_n  = 1'b1;
            ticks_n = tick ? cnt_sat : cnt;
            cnt_n   = '0;
        end else if (!sw_open_q && sw_open_d) begin
            cnt_n = '0;
        end else if (sw_open_q && tick) begin
            cnt_n = cnt_sat;
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            win_done  <= 1'b0;
            win_ticks <= '0;
        end else begin
            cnt       <= cnt_n;
            win_done  <= done_n;
            win_ticks <= ticks_n;
        end
    end

endmodule

// File: rtl/intwin_ctrl.sv
// Module: top of the integration window timer.
// Ties the control register, period lookup and sequencer together and
// drives the shared gain select. Assumes tick is a single-cycle pulse.
module intwin_ctrl
    import intwin_pkg::*;
#(
    parameter int TICKS_SHORT = 14,
    parameter int TICKS_MID   = 101,
    parameter int TICKS_LONG  = 402,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    output logic             gain_hi,
    output logic             win_open,
    output logic             win_done,
    output logic [CNT_W-1:0] win_ticks
);

    logic [7:0]       ctl_q;
    per_code_e        code_q, code_d;
    logic             man_d;
    logic [CNT_W-1:0] period;

    assign code_q  = per_code_e'(ctl_q[1:0]);
    assign rd_data = ctl_q;
    assign gain_hi = ctl_q[GAIN_BIT];

    intwin_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl_q   (ctl_q),
        .code_d  (code_d),
        .man_d   (man_d)
    );

    intwin_period_sel #(
        .TICKS_SHORT (TICKS_SHORT),
        .TICKS_MID   (TICKS_MID),
        .TICKS_LONG  (TICKS_LONG),
        .CNT_W       (CNT_W)
    ) u_per (
        .code   (code_q),
        .period (period)
    );

    intwin_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .code_q    (code_q),
        .code_d    (code_d),
        .man_q     (ctl_q[MAN_BIT]),
        .man_d     (man_d),
        .period    (period),
        .win_open  (win_open),
        .win_done  (win_done),
        .win_ticks (win_ticks)
    );

endmodule

// File: rtl/intwin_ctrl_chk.sv
// Module: port-level property checker for intwin_ctrl, bound below.
// Assumes the same parameter values as the instance it watches.
module intwin_ctrl_chk #(
    parameter int TICKS_SHORT = 14,
    parameter int TICKS_MID   = 101,
    parameter int TICKS_LONG  = 402,
    parameter int CNT_W       = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wr_en,
    input logic             wr_gain,
    input logic [7:0]       rd_data,
    input logic             gain_hi,
    input logic             win_open,
    input logic             win_done,
    input logic [CNT_W-1:0] win_ticks
);

    localparam logic [CNT_W-1:0] LEN_S = CNT_W'(TICKS_SHORT);
    localparam logic [CNT_W-1:0] LEN_M = CNT_W'(TICKS_MID);
    localparam logic [CNT_W-1:0] LEN_L = CNT_W'(TICKS_LONG);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 8'h02 && !win_done && win_ticks == '0));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & 8'hE4) == 8'h00);

    // R3
    gain_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (gain_hi == $past(wr_gain)));

    // R4
    fixed_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && rd_data[1:0] != 2'b11) |->
        (win_ticks == ((rd_data[1:0] == 2'b00) ? LEN_S :
                       (rd_data[1:0] == 2'b01) ? LEN_M : LEN_L)));

    // R7
    sw_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && rd_data[1:0] == 2'b11) |-> (!win_open && !rd_data[3]));

    // R8
    fixed_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1:0] != 2'b11) |-> win_open);

    // R11
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> ($past(tick) || $past(wr_en)));

endmodule

bind intwin_ctrl intwin_ctrl_chk #(
    .TICKS_SHORT (TICKS_SHORT),
    .TICKS_MID   (TICKS_MID),
    .TICKS_LONG  (TICKS_LONG),
    .CNT_W       (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_en     (wr_en),
    .wr_gain   (wr_data[4]),
    .rd_data   (rd_data),
    .gain_hi   (gain_hi),
    .win_open  (win_open),
    .win_done  (win_done),
    .win_ticks (win_ticks)
);

// File: tb/intwin_ctrl_test.sv
// Bench: sweeps fixed codes, tick spacings and software window lengths
// on a short-period configuration and predicts each pulse arithmetically.
module intwin_ctrl_test;

    localparam int PS = 3;
    localparam int PM = 5;
    localparam int PL = 9;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic [7:0]    rd_data;
    logic          gain_hi;
    logic          win_open;
    logic          win_done;
    logic [CW-1:0] win_ticks;

    int vectors = 0;
    int errors  = 0;

    intwin_ctrl #(
        .TICKS_SHORT (PS),
        .TICKS_MID   (PM),
        .TICKS_LONG  (PL),
        .CNT_W       (CW)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .gain_hi   (gain_hi),
        .win_open  (win_open),
        .win_done  (win_done),
        .win_ticks (win_ticks)
    );

    always #2 clk = ~clk;

    // Record one comparison; report on mismatch.
    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle from a falling edge; return at the next falling edge.
    task automatic cyc(input logic t, input logic w, input logic [7:0] d);
        tick = t; wr_en = w; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
    endtask

    function automatic int per_of(input int code);
        return (code == 0) ? PS : (code == 1) ? PM : PL;
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int nt;
        int n;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "rd_data", int'(rd_data), 2);
        check("R1", "gain_hi", int'(gain_hi), 0);
        check("R1", "win_done", int'(win_done), 0);
        check("R1", "win_ticks", int'(win_ticks), 0);
        check("R1", "win_open", int'(win_open), 1);

        // R4: fixed codes against tick spacings and both gains
        for (int code = 0; code < 3; code++) begin
            for (int gap = 1; gap <= 3; gap++) begin
                for (int g = 0; g < 2; g++) begin
                    n = per_of(code);
                    cyc(1'b0, 1'b1, 8'h03);
                    cyc(1'b0, 1'b1, 8'((g << 4) | code));
                    check("R3", "gain_hi", int'(gain_hi), g);
                    nt = 0;
                    for (int i = 0; i < 3 * n * gap; i++) begin
                        logic t;
                        t = ((i % gap) == gap - 1);
                        cyc(t, 1'b0, 8'h00);
                        if (t) nt++;
                        check("R4", "win_done", int'(win_done), int'(t && (nt % n == 0)));
                        check("R4", "win_open", int'(win_open), 1);
                        if (t && (nt % n == 0))
                            check("R4", "win_ticks", int'(win_ticks), n);
                    end
                end
            end
        end

        // R5: code change restarts count, tick in change cycle dropped
        cyc(1'b0, 1'b1, 8'h03);
        cyc(1'b0, 1'b1, 8'h02);
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 8'h00);
        cyc(1'b1, 1'b1, 8'h01);
        check("R5", "win_done on change", int'(win_done), 0);
        for (int i = 1; i <= PM; i++) begin
            cyc(1'b1, 1'b0, 8'h00);
            check("R5", "win_done after change", int'(win_done), int'(i == PM));
        end
        // R5: same-code write keeps count (gain change only)
        cyc(1'b1, 1'b0, 8'h00);
        cyc(1'b1, 1'b0, 8'h00);
        cyc(1'b1, 1'b1, 8'h11);
        check("R5", "win_done on same-code write", int'(win_done), 0);
        check("R3", "gain_hi", int'(gain_hi), 1);
        cyc(1'b1, 1'b0, 8'h00);
        check("R5", "win_done tick4", int'(win_done), 0);
        cyc(1'b1, 1'b0, 8'h00);
        check("R5", "win_done tick5", int'(win_done), 1);
        check("R5", "win_ticks", int'(win_ticks), PM);

        // R6 R7 R11: software windows of every short length
        for (int d = 0; d <= 12; d++) begin
            for (int st = 0; st < 2; st++) begin
                cyc(1'b0, 1'b1, 8'h03);
                cyc(1'b1, 1'b1, 8'h0B);
                check("R6", "win_open after start", int'(win_open), 1);
                for (int i = 0; i < d; i++) begin
                    cyc(1'b1, 1'b0, 8'h00);
                    check("R6", "win_done while open", int'(win_done), 0);
                    cyc(1'b0, 1'b0, 8'h00);
                end
                cyc(logic'(st), 1'b1, 8'h03);
                check("R7", "win_done at stop", int'(win_done), 1);
                check("R7", "win_ticks", int'(win_ticks), d + st);
                check("R7", "win_open after stop", int'(win_open), 0);
                cyc(1'b1, 1'b0, 8'h00);
                check("R11", "win_done second cycle", int'(win_done), 0);
                check("R11", "win_ticks held", int'(win_ticks), d + st);
            end
        end

        // R10: saturation of the software count
        cyc(1'b0, 1'b1, 8'h0B);
        for (int i = 0; i < 300; i++) cyc(1'b1, 1'b0, 8'h00);
        cyc(1'b0, 1'b1, 8'h03);
        check("R10", "win_ticks saturated", int'(win_ticks), (1 << CW) - 1);

        // R8: control bit toggled in a fixed code changes nothing
        cyc(1'b0, 1'b1, 8'h00);
        cyc(1'b1, 1'b0, 8'h00);
        cyc(1'b1, 1'b0, 8'h00);
        cyc(1'b0, 1'b1, 8'h08);
        check("R8", "win_done on set", int'(win_done), 0);
        check("R8", "win_open on set", int'(win_open), 1);
        cyc(1'b1, 1'b0, 8'h00);
        check("R8", "win_done period end", int'(win_done), 1);
        cyc(1'b0, 1'b1, 8'h00);
        check("R8", "win_done on clear", int'(win_done), 0);
        for (int i = 1; i <= PS; i++) begin
            cyc(1'b1, 1'b0, 8'h00);
            check("R8", "win_done next window", int'(win_done), int'(i == PS));
        end

        // R9: leaving software mode with window open
        cyc(1'b0, 1'b1, 8'h0B);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 8'h00);
        cyc(1'b0, 1'b1, 8'h01);
        check("R9", "win_done on exit", int'(win_done), 0);
        check("R9", "win_open on exit", int'(win_open), 1);
        for (int i = 1; i <= PM; i++) begin
            cyc(1'b1, 1'b0, 8'h00);
            check("R9", "win_done after exit", int'(win_done), int'(i == PM));
        end

        // R2 R3: every write value reads back masked
        for (int v = 0; v < 256; v++) begin
            cyc(1'b0, 1'b1, 8'(v));
            check("R2", "rd_data", int'(rd_data), v & 8'h1B);
            check("R3", "gain_hi", int'(gain_hi), (v >> 4) & 1);
        end

        // R1: reset again from a written state
        rst_n = 1'b0;
        cyc(1'b0, 1'b0, 8'h00);
        rst_n = 1'b1;
        check("R1", "rd_data after reset", int'(rd_data), 2);
        check("R1", "win_ticks after reset", int'(win_ticks), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule